// File: doc/BRIEF.md
# Atomic Add Retry Sequencer

This block is a bus master that adds a signed operand to one 32-bit word in shared memory so that no other agent's update is lost. On a start request it latches the target address and the operand. It then issues a load-exclusive of the word, forms the wrapping two's-complement sum, and issues a store-exclusive of that sum to the same address.

The exclusive monitor answers every store-exclusive with a status bit. A status of 0 means the store took effect and the operation ends. A status of 1 means another agent touched the word, so the store was refused. In that case the sequencer goes back and issues a fresh load-exclusive. It keeps looping until a store succeeds or until the number of refused stores exceeds a parameterised limit, which ends the operation with an error flag.

The memory side is a simple request/response port. A request is a one-cycle pulse, and the answer arrives with an acknowledge no earlier than the following cycle. Only one request is outstanding at a time.

Top module: `atomic_add_seq`

## Requirements
- R1: After a synchronous active-low reset, `mem_req`, `op_done`, `op_error` are 0 and `op_retries` is 0.
- R2: The cycle after `op_start` is sampled high in the idle state, `mem_req` is high with `mem_excl_store`=0 (load-exclusive) and `mem_addr` equal to the latched `op_addr`.
- R3: Every store-exclusive (`mem_req` high with `mem_excl_store`=1) targets the address of the preceding load-exclusive and carries as `mem_wdata` the value returned by that load plus the latched operand.
- R4: When a store-exclusive is acknowledged with `mem_status`=0, `op_done` goes high for exactly one cycle and no further request is issued.
- R5: When a store-exclusive is acknowledged with `mem_status`=1, the sequencer issues a new load-exclusive and the next store is built from the newly returned value, so the final word includes every intervening update by other agents.
- R6: `op_retries` equals the number of refused store-exclusives in the current operation. It is cleared when a start is accepted and holds its value after `op_done`.
- R7: When the refused count would exceed `RETRY_LIMIT`, the sequencer stops after the refusal with `op_retries` = `RETRY_LIMIT`+1, `op_error`=1 and a one-cycle `op_done`, and issues no further request. `op_error` clears when the next start is accepted.
- R8: The addition is 32-bit two's complement and wraps on overflow in both directions.
- R9: `op_start` asserted while an operation is in progress has no effect: address, operand and request count of the running operation are unchanged.
- R10: `mem_req` is never high in two consecutive cycles and is never raised while a request awaits its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Start an atomic add (accepted only when idle) |
| op_addr | input | ADDR_W | Byte address of the target word |
| op_addend | input | DATA_W | Signed operand to add |
| op_done | output | 1 | One-cycle completion pulse |
| op_retries | output | CNT_W | Refused store-exclusive count of the current/last operation |
| op_error | output | 1 | Retry limit exceeded in the last operation |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_excl_store | output | 1 | 0 = load-exclusive, 1 = store-exclusive |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Store-exclusive data |
| mem_ack | input | 1 | Response valid |
| mem_rdata | input | DATA_W | Load-exclusive data |
| mem_status | input | 1 | Store-exclusive result, 0 = stored, 1 = refused |

## Verification
The hardest situation to reach from the ports is a refused store with a real competing write behind it. If that case goes wrong, a sequencer that reuses the stale loaded value still looks correct. The bench memory model therefore takes a per-operation budget of refusals. On each refusal it also adds an interference value to the word, as a rival agent would, so the final word only matches when every retry re-reads memory. Budgets of exactly the limit and one past it reach both sides of the error boundary, and the response latency is varied between operations.

// File: rtl/atom_pkg.sv
// Shared types for the atomic add sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package atom_pkg;

    // Control states of the sequencer
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_LOAD       = 3'd1,
        ST_WAIT_LOAD  = 3'd2,
        ST_ADD        = 3'd3,
        ST_STORE      = 3'd4,
        ST_WAIT_STORE = 3'd5,
        ST_DONE       = 3'd6
    } seq_state_t;

endpackage

// File: rtl/atom_ctrl.sv
// Control state machine of the atomic add sequencer.
// Does: walks load-exclusive, add, store-exclusive, and loops back on a refused store.
// Assumes: the responder acknowledges at least one cycle after a request pulse,
// and at_limit reports that the refused count already equals the limit.
module atom_ctrl
    import atom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mem_ack,
    input  logic       mem_status,
    input  logic       at_limit,
    output seq_state_t state,
    output logic       accept,
    output logic       load_cap,
    output logic       sum_en,
    output logic       fail_evt,
    output logic       err_set,
    output logic       mem_req,
    output logic       mem_excl_store,
    output logic       done
);

    seq_state_t state_q, state_d;

    // Next-state and strobe decode
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        load_cap = 1'b0;
        sum_en   = 1'b0;
        fail_evt = 1'b0;
        err_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD:      state_d = ST_WAIT_LOAD;
            ST_WAIT_LOAD: begin
                if (mem_ack) begin
                    load_cap = 1'b1;
                    state_d  = ST_ADD;
                end
            end
            ST_ADD: begin
                sum_en  = 1'b1;
                state_d = ST_STORE;
            end
            ST_STORE:     state_d = ST_WAIT_STORE;
            ST_WAIT_STORE: begin
                if (mem_ack) begin
                    if (!mem_status) begin
                        state_d = ST_DONE;
                    end else begin
                        fail_evt = 1'b1;
                        if (at_limit) begin
                            err_set = 1'b1;
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_LOAD;
                        end
                    end
                end
            end
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bus and completion outputs decoded from the registered state
    always_comb begin
        mem_req        = (state_q == ST_LOAD) || (state_q == ST_STORE);
        mem_excl_store = (state_q == ST_STORE);
        done           = (state_q == ST_DONE);
    end

    assign state = state_q;

endmodule

// File: rtl/atom_datapath.sv
// Datapath of the atomic add sequencer.
// Does: holds the target address and operand, captures the loaded word and
// forms the wrapping sum that the store-exclusive writes.
// Assumes: strobes come from atom_ctrl and are mutually exclusive.
module atom_datapath #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              load_cap,
    input  logic              sum_en,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_addend,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] addend_q;
    logic [DATA_W-1:0] loaded_q;
    logic [DATA_W-1:0] sum_q;

    // Latch the request fields when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            addend_q <= '0;
        end else if (accept) begin
            addr_q   <= op_addr;
            addend_q <= op_addend;
        end
    end

    // Capture the value returned by each load-exclusive
    always_ff @(posedge clk) begin
        if (!rst_n)        loaded_q <= '0;
        else if (load_cap) loaded_q <= mem_rdata;
    end

    // Register the modulo-2^DATA_W sum for the store-exclusive
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (sum_en) sum_q <= loaded_q + addend_q;
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = sum_q;

endmodule

// File: rtl/atom_retry.sv
// Retry bookkeeping of the atomic add sequencer.
// Does: counts refused store-exclusives per operation and flags an overrun.
// Assumes: fail_evt pulses once per refused store; accept clears both values.
module atom_retry #(
    parameter int RETRY_LIMIT = 3,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             fail_evt,
    input  logic             err_set,
    output logic             at_limit,
    output logic [CNT_W-1:0] count,
    output logic             error
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(RETRY_LIMIT);

    logic [CNT_W-1:0] count_q;
    logic             error_q;

    // Count refused stores of the current operation
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (accept)   count_q <= '0;
        else if (fail_evt) count_q <= count_q + 1'b1;
    end

    // Error flag: set on overrun, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)       error_q <= 1'b0;
        else if (accept)  error_q <= 1'b0;
        else if (err_set) error_q <= 1'b1;
    end

    assign at_limit = (count_q == LIMIT_V);
    assign count    = count_q;
    assign error    = error_q;

endmodule

// File: rtl/atomic_add_seq.sv
// Top of the atomic add sequencer.
// Does: performs load-exclusive / add / store-exclusive and retries on a refused store
// until success or until RETRY_LIMIT refusals have been exceeded.
// Assumes: an external exclusive monitor and memory answer one request at a time.
module atomic_add_seq #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int RETRY_LIMIT = 3,
    parameter int CNT_W       = $clog2(RETRY_LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_addend,
    output logic              op_done,
    output logic [CNT_W-1:0]  op_retries,
    output logic              op_error,
    output logic              mem_req,
    output logic              mem_excl_store,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_status
);

    import atom_pkg::*;

    seq_state_t state;
    logic accept, load_cap, sum_en, fail_evt, err_set, at_limit;

    atom_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (op_start),
        .mem_ack        (mem_ack),
        .mem_status     (mem_status),
        .at_limit       (at_limit),
        .state          (state),
        .accept         (accept),
        .load_cap       (load_cap),
        .sum_en         (sum_en),
        .fail_evt       (fail_evt),
        .err_set        (err_set),
        .mem_req        (mem_req),
        .mem_excl_store (mem_excl_store),
        .done           (op_done)
    );

    atom_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .load_cap  (load_cap),
        .sum_en    (sum_en),
        .op_addr   (op_addr),
        .op_addend (op_addend),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    atom_retry #(
        .RETRY_LIMIT (RETRY_LIMIT),
        .CNT_W       (CNT_W)
    ) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .fail_evt (fail_evt),
        .err_set  (err_set),
        .at_limit (at_limit),
        .count    (op_retries),
        .error    (op_error)
    );

endmodule

// File: rtl/atomic_add_seq_chk.sv
// Protocol checker for atomic_add_seq, attached with bind.
// Does: watches the port-level rules of the request pulse, completion and retry count.
module atomic_add_seq_chk #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int RETRY_LIMIT = 3,
    parameter int CNT_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_done,
    input logic [CNT_W-1:0]  op_retries,
    input logic              op_error,
    input logic              mem_req,
    input logic              mem_excl_store,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [ADDR_W-1:0] ld_addr_q;

    // Remember the address of the latest load-exclusive
    always_ff @(posedge clk) begin
        if (!rst_n)                         ld_addr_q <= '0;
        else if (mem_req && !mem_excl_store) ld_addr_q <= mem_addr;
    end

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R7
    error_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_error) |-> op_done);

    // R6
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_retries <= CNT_W'(RETRY_LIMIT + 1));

    // R3
    store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_excl_store) |-> (mem_addr == ld_addr_q));

endmodule

bind atomic_add_seq atomic_add_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RETRY_LIMIT (RETRY_LIMIT),
    .CNT_W       (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_done        (op_done),
    .op_retries     (op_retries),
    .op_error       (op_error),
    .mem_req        (mem_req),
    .mem_excl_store (mem_excl_store),
    .mem_addr       (mem_addr)
);

// File: tb/atomic_add_seq_test.sv
// Scoreboard bench for atomic_add_seq with a failure-injecting memory model.
module atomic_add_seq_test;

    localparam int LIMIT = 3;
    localparam int CW    = $clog2(LIMIT + 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_addend = '0;
    logic        op_done;
    logic [CW-1:0] op_retries;
    logic        op_error;
    logic        mem_req, mem_excl_store;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_status = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    atomic_add_seq #(.RETRY_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_addr(op_addr),
        .op_addend(op_addend), .op_done(op_done), .op_retries(op_retries),
        .op_error(op_error), .mem_req(mem_req), .mem_excl_store(mem_excl_store),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_status(mem_status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- memory and monitor model ----------------
    logic [31:0] mem [0:15];
    int          fail_budget = 0;
    logic [31:0] interfere   = '0;
    int          lat         = 0;
    int          req_cnt     = 0;
    logic [31:0] cur_addend  = '0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[5:2]);
    endfunction

    initial begin
        logic [31:0] last_rd;
        logic [31:0] last_ld_addr;
        bit          tag_ok;
        logic [31:0] a;
        bit          st;
        logic [31:0] wd;
        last_rd = '0; last_ld_addr = '0; tag_ok = 0;
        for (int i = 0; i < 16; i++) mem[i] = 32'h1000 * i;
        @(negedge clk);
        forever begin
            if (rst_n && mem_req) begin
                req_cnt++;
                a = mem_addr; st = mem_excl_store; wd = mem_wdata;
                if (st) begin
                    // R3: stored value is the last loaded value plus the operand
                    check(wd == last_rd + cur_addend, "R3", "store data", wd, last_rd + cur_addend);
                    check(a == last_ld_addr, "R3", "store address", a, last_ld_addr);
                end
                for (int k = 0; k <= lat; k++) begin
                    @(negedge clk);
                    // R10: no request while one is outstanding
                    if (mem_req) check(0, "R10", "request while outstanding", 1, 0);
                end
                mem_ack = 1'b1;
                if (!st) begin
                    mem_rdata    = mem[widx(a)];
                    last_rd      = mem_rdata;
                    last_ld_addr = a;
                    tag_ok       = 1;
                    mem_status   = 1'b0;
                end else if (fail_budget > 0) begin
                    fail_budget--;
                    mem[widx(a)] = mem[widx(a)] + interfere;
                    mem_status   = 1'b1;
                    tag_ok       = 0;
                end else begin
                    if (tag_ok && a == last_ld_addr) mem[widx(a)] = wd;
                    mem_status = 1'b0;
                    tag_ok     = 0;
                end
                @(negedge clk);
                mem_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] addr;
        logic [31:0] value;
        int          retries;
        bit          err;
    } exp_t;

    exp_t sb_q[$];
    int   done_cnt = 0;

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && op_done) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    check(0, "R4", "unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(int'(op_retries) == e.retries, "R6", "retry count", 32'(op_retries), 32'(e.retries));
                    check(op_error == e.err, "R7", "error flag", 32'(op_error), 32'(e.err));
                    check(mem[widx(e.addr)] == e.value, "R5", "final word", mem[widx(e.addr)], e.value);
                end
                @(negedge clk);
                check(op_done == 1'b0, "R4", "done width", 32'(op_done), 0);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_op(input logic [31:0] a, input logic [31:0] addend,
                          input int nfail, input logic [31:0] interf,
                          input int latency, input bit poke);
        exp_t e;
        int   eff;
        bit   ok;
        int   prev;
        logic [31:0] other;
        eff = (nfail > LIMIT) ? LIMIT + 1 : nfail;
        ok  = (nfail <= LIMIT);
        e.addr    = a;
        e.value   = mem[widx(a)] + interf * eff + (ok ? addend : 32'd0);
        e.retries = eff;
        e.err     = !ok;
        sb_q.push_back(e);
        fail_budget = nfail; interfere = interf; lat = latency;
        cur_addend = addend; req_cnt = 0;
        prev  = done_cnt;
        other = mem[widx(a ^ 32'h4)];
        op_addr = a; op_addend = addend; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        // R2: load-exclusive request the cycle after start
        check(mem_req && !mem_excl_store && mem_addr == a, "R2", "load request", mem_addr, a);
        if (poke) begin
            repeat (3) @(negedge clk);
            op_addr = a ^ 32'h4; op_addend = 32'h5555; op_start = 1'b1;
            @(negedge clk);
            op_start = 1'b0;
        end
        while (done_cnt == prev) @(negedge clk);
        repeat (4) @(negedge clk);
        // R7/R10: exact request count, none after completion
        check(req_cnt == 2 * (eff + (ok ? 1 : 0)), "R7", "request count", 32'(req_cnt), 32'(2 * (eff + (ok ? 1 : 0))));
        if (poke) begin
            // R9: ignored start left the other word untouched and no extra operation ran
            check(mem[widx(a ^ 32'h4)] == other, "R9", "other word", mem[widx(a ^ 32'h4)], other);
            check(done_cnt == prev + 1, "R9", "done count", 32'(done_cnt), 32'(prev + 1));
        end
        fail_budget = 0;
    endtask

    // ---------------- watchdog ----------------
    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!mem_req && !op_done && !op_error && op_retries == 0, "R1", "reset outputs",
              {mem_req, op_done, op_error, 29'(op_retries)}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !op_done, "R1", "idle after reset", 32'(mem_req), 0);

        mem[4] = 32'd100;
        run_op(32'h10, 32'd5, 0, 32'd0, 0, 0);              // clean pass
        run_op(32'h10, 32'hFFFF_FFFD, 2, 32'd7, 2, 0);      // R5 two refusals with interference
        mem[2] = 32'hFFFF_FFFE;
        run_op(32'h08, 32'd5, 0, 32'd0, 1, 0);              // R8 wrap upward
        check(mem[2] == 32'd3, "R8", "upward wrap", mem[2], 32'd3);
        mem[3] = 32'h8000_0000;
        run_op(32'h0C, 32'hFFFF_FFFF, 0, 32'd0, 0, 0);      // R8 wrap downward
        check(mem[3] == 32'h7FFF_FFFF, "R8", "downward wrap", mem[3], 32'h7FFF_FFFF);
        run_op(32'h20, 32'd9, LIMIT, 32'd1, 1, 0);          // R6 exactly at limit
        run_op(32'h24, 32'd9, LIMIT + 2, 32'd3, 0, 0);      // R7 overrun
        check(op_error == 1'b1, "R7", "error held after done", 32'(op_error), 1);
        run_op(32'h30, 32'd11, 1, 32'd2, 3, 1);             // R9 start poked while busy
        check(op_error == 1'b0, "R7", "error cleared by new start", 32'(op_error), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule